// File: doc/BRIEF.md
# ADC Sample-Timing and Abort Sequencer

This block paces one analog-to-digital conversion at a time. A start trigger opens a sample phase whose length is set by a long-sample enable, a 2-bit long-sample length code and a high-speed flag. The length also depends on whether this conversion opens a run or follows the previous one automatically in continuous mode. A fixed-length convert phase follows the sample phase. The analog converter is modelled by a stub that hands back a test word. The result register and its valid flag take the new value in the same cycle as a one-cycle completion pulse.

The sequencer also stops conversions when the system asks it to. A low-power stop request aborts the conversion and wipes the result. So does the block reset. A normal stop request aborts the conversion only while the asynchronous clock enable is low, and it leaves the last good result in place. A clock-request output tells the asynchronous conversion-clock generator when it must run. It is raised permanently when the enable is set, and otherwise only while a conversion is in flight.

Top module: `adc_sample_seq`

## Requirements
- R1: After reset, `result_o` is 0, and `valid_o`, `sample_o` and `done_o` are low. `clk_req_o` is low when `aclk_en_i` is low.
- R2: With `lsmp_en_i` low, the sample phase lasts 6 cycles for a first conversion and 4 for a later one. With `hs_en_i` high these become 8 and 6.
- R3: With `lsmp_en_i` high, `lsmp_sel_i` values 0, 1, 2 and 3 give 24, 16, 10 and 6 sample cycles. Each is 2 cycles longer with `hs_en_i` high. First and later conversions use the same length.
- R4: A conversion started automatically in continuous mode is a later conversion. One started by a trigger, including a restart, is a first conversion.
- R5: The convert phase lasts 16 cycles after the sample phase. `done_o` is then high for one cycle, and in that same cycle `result_o` takes the value 0xA50 plus the number of completions since the last clear (modulo 2^12), and `valid_o` is high.
- R6: With `cont_i` high at completion, the next sample phase starts in the cycle in which `done_o` is high. With `cont_i` low at completion, the sequencer goes idle.
- R7: `nstop_i` high while `aclk_en_i` is low aborts a conversion. There is no `done_o`, and `result_o` and `valid_o` stay unchanged.
- R8: `nstop_i` high while `aclk_en_i` is high does not disturb a conversion.
- R9: `lp_stop_i` high, or reset, aborts a conversion and returns `result_o`, `valid_o` and the completion count to 0.
- R10: A trigger during an active conversion aborts it without a result update and restarts it as a first conversion. This also applies on the final convert cycle, where the restart wins and no `done_o` is produced.
- R11: A trigger is ignored while `lp_stop_i` is high, or while `nstop_i` is high with `aclk_en_i` low.
- R12: `clk_req_o` is high whenever `aclk_en_i` is high. Otherwise it is high exactly while a sample or convert phase is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion trigger, one cycle |
| cont_i | input | 1 | Continuous-run enable |
| lsmp_en_i | input | 1 | Long-sample enable |
| lsmp_sel_i | input | 2 | Long-sample length code |
| hs_en_i | input | 1 | High-speed mode |
| lp_stop_i | input | 1 | Low-power stop request |
| nstop_i | input | 1 | Normal stop request |
| aclk_en_i | input | 1 | Keep asynchronous clock running |
| sample_o | output | 1 | High during the sample phase |
| clk_req_o | output | 1 | Request to the asynchronous clock generator |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Last completed result |
| valid_o | output | 1 | Result holds a completed conversion |

## Verification
A completion and a fresh trigger can fall on the same edge. The bench provokes this by driving the trigger so that it is sampled on the edge that ends the last convert cycle. The restart must win: the scoreboard expects no completion at that edge, which would otherwise pop its queued item too early with the wrong cycle stamp. It then expects a first-length sample run, and a completion stamped from the restart edge that carries the result index left unadvanced by the lost conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } seq_state_e;

  localparam int unsigned SHORT_BASE  = 4;
  localparam int unsigned FIRST_EXTRA = 2;
  localparam int unsigned HS_EXTRA    = 2;
  localparam int unsigned LONG_C0     = 24;
  localparam int unsigned LONG_C1     = 16;
  localparam int unsigned LONG_C2     = 10;
  localparam int unsigned LONG_C3     = 6;
  localparam int unsigned SMP_MAX     = LONG_C0 + HS_EXTRA;
endpackage

// File: rtl/adc_smp_len.sv
module adc_smp_len
  import adc_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             lsmp_en_i,
  input  logic [1:0]       lsmp_sel_i,
  input  logic             hs_en_i,
  input  logic             first_i,
  output logic [CNT_W-1:0] len_o
);
  int unsigned base_cyc;
  int unsigned tot_cyc;

  always_comb begin
    if (lsmp_en_i) begin
      unique case (lsmp_sel_i)
        2'd0:    base_cyc = LONG_C0;
        2'd1:    base_cyc = LONG_C1;
        2'd2:    base_cyc = LONG_C2;
        default: base_cyc = LONG_C3;
      endcase
    end else begin
      base_cyc = SHORT_BASE + (first_i ? FIRST_EXTRA : 0);
    end
    tot_cyc = base_cyc + (hs_en_i ? HS_EXTRA : 0);
    len_o   = CNT_W'(tot_cyc);
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 16,
  parameter int unsigned CNT_W       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic             abort_keep_i,
  input  logic             abort_clr_i,
  input  logic [CNT_W-1:0] smp_len_i,
  output logic             first_o,
  output logic             sample_o,
  output logic             busy_o,
  output logic             complete_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q;
  logic             abort;
  logic             cnt_en;
  logic             at_end;

  assign abort  = abort_keep_i | abort_clr_i;
  assign at_end = (cnt_q == '0);
  assign first_o = ~((state_q == ST_CONVERT) && at_end && cont_i && !start_i && !abort);

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    complete_o = 1'b0;
    if (abort) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (start_i) begin
      state_d = ST_SAMPLE;
      cnt_d   = smp_len_i - ONE;
    end else begin
      unique case (state_q)
        ST_SAMPLE: begin
          if (at_end) begin
            state_d = ST_CONVERT;
            cnt_d   = CONV_LAST;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        ST_CONVERT: begin
          if (at_end) begin
            complete_o = 1'b1;
            if (cont_i) begin
              state_d = ST_SAMPLE;
              cnt_d   = smp_len_i - ONE;
            end else begin
              state_d = ST_IDLE;
            end
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign cnt_en = (state_q != ST_IDLE) || (state_d != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= complete_o;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign sample_o = (state_q == ST_SAMPLE);
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !abort_keep_i && !abort_clr_i) |=> (sample_o && !done_o));

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int unsigned       DATA_W = 12,
  parameter logic [DATA_W-1:0] SEED   = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              complete_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] res_q, res_d;
  logic [DATA_W-1:0] idx_q, idx_d;
  logic              val_q, val_d;
  logic              upd_en;

  assign upd_en = clr_i | complete_i;

  always_comb begin
    if (clr_i) begin
      res_d = '0;
      idx_d = '0;
      val_d = 1'b0;
    end else begin
      res_d = SEED + idx_q;
      idx_d = idx_q + DATA_W'(1);
      val_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      idx_q <= '0;
      val_q <= 1'b0;
    end else if (upd_en) begin
      res_q <= res_d;
      idx_q <= idx_d;
      val_q <= val_d;
    end
  end

  assign result_o = res_q;
  assign valid_o  = val_q;

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!valid_o && result_o == '0));
endmodule

// File: rtl/adc_sample_seq.sv
module adc_sample_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned       DATA_W      = 12,
  parameter logic [DATA_W-1:0] RESULT_SEED = 12'hA50,
  parameter int unsigned       CONV_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cont_i,
  input  logic              lsmp_en_i,
  input  logic [1:0]        lsmp_sel_i,
  input  logic              hs_en_i,
  input  logic              lp_stop_i,
  input  logic              nstop_i,
  input  logic              aclk_en_i,
  output logic              sample_o,
  output logic              clk_req_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o
);
  localparam int unsigned CNT_MAX = (SMP_MAX > CONV_CYCLES) ? SMP_MAX : CONV_CYCLES;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             first;
  logic [CNT_W-1:0] smp_len;
  logic             busy;
  logic             complete;
  logic             abort_keep;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  assign abort_keep = nstop_i & ~aclk_en_i;

  adc_smp_len #(
    .CNT_W (CNT_W)
  ) u_len (
    .lsmp_en_i  (lsmp_en_i),
    .lsmp_sel_i (lsmp_sel_i),
    .hs_en_i    (hs_en_i),
    .first_i    (first),
    .len_o      (smp_len)
  );

  adc_seq_fsm #(
    .CONV_CYCLES (CONV_CYCLES),
    .CNT_W       (CNT_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .start_i      (start_i),
    .cont_i       (cont_i),
    .abort_keep_i (abort_keep),
    .abort_clr_i  (lp_stop_i),
    .smp_len_i    (smp_len),
    .first_o      (first),
    .sample_o     (sample_o),
    .busy_o       (busy),
    .complete_o   (complete),
    .done_o       (done_o)
  );

  adc_result_reg #(
    .DATA_W (DATA_W),
    .SEED   (RESULT_SEED)
  ) u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .clr_i      (lp_stop_i),
    .complete_i (complete),
    .result_o   (result_o),
    .valid_o    (valid_o)
  );

  assign clk_req_o = aclk_en_i | busy;

  // R7
  keep_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (nstop_i && !aclk_en_i && !lp_stop_i) |=> ($stable(result_o) && $stable(valid_o)));

  // R5
  done_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    done_o |-> valid_o);

  // R12
  sample_req_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    sample_o |-> clk_req_o);
endmodule

// File: tb/adc_sample_seq_bench.sv
module adc_sample_seq_bench;
  localparam int unsigned CONV = 16;
  localparam logic [11:0] SEED = 12'hA50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, cont_i, lsmp_en_i, hs_en_i, lp_stop_i, nstop_i, aclk_en_i;
  logic [1:0]  lsmp_sel_i;
  logic        sample_o, clk_req_o, done_o, valid_o;
  logic [11:0] result_o;

  always #2 clk = ~clk;

  adc_sample_seq u_adc_sample_seq (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start_i), .cont_i (cont_i),
    .lsmp_en_i (lsmp_en_i), .lsmp_sel_i (lsmp_sel_i), .hs_en_i (hs_en_i),
    .lp_stop_i (lp_stop_i), .nstop_i (nstop_i), .aclk_en_i (aclk_en_i),
    .sample_o (sample_o), .clk_req_o (clk_req_o), .done_o (done_o),
    .result_o (result_o), .valid_o (valid_o)
  );

  typedef struct {
    int unsigned at;
    logic [11:0] data;
  } exp_t;

  exp_t        done_q[$];
  int unsigned smp_q[$];
  int unsigned cyc = 0;
  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  int unsigned n_cmp = 0;
  int unsigned n_seen = 0;
  int unsigned run = 0;
  int unsigned t_ref = 0;
  bit          finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned exp_len(bit l, logic [1:0] s, bit h, bit first);
    int unsigned v;
    if (l) begin
      case (s)
        2'd0: v = 24;
        2'd1: v = 16;
        2'd2: v = 10;
        default: v = 6;
      endcase
    end else begin
      v = first ? 6 : 4;
    end
    return v + (h ? 2 : 0);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (done_o) begin
      n_seen++;
      if (done_q.size() == 0) begin
        check("R10", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = done_q.pop_front();
        check("R5", "done cycle", cyc, e.at);
        check("R5", "result word", result_o, e.data);
        check("R5", "valid at done", valid_o, 1);
      end
    end
    if (sample_o) begin
      run++;
    end else if (run != 0) begin
      if (smp_q.size() == 0) check("R11", "unexpected sample run", run, 0);
      else check("R2 R3", "sample length", run, smp_q.pop_front());
      run = 0;
    end
  end

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t_ref = cyc;
  endtask

  task automatic wait_cyc(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain();
    while (done_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic push_done(input int unsigned at);
    exp_t e;
    e.at = at;
    e.data = 12'(SEED + n_cmp);
    done_q.push_back(e);
    n_cmp++;
  endtask

  task automatic set_cfg(input bit l, input logic [1:0] s, input bit h, input bit c);
    lsmp_en_i = l; lsmp_sel_i = s; hs_en_i = h; cont_i = c;
  endtask

  task automatic run_single(input bit l, input logic [1:0] s, input bit h);
    int unsigned len;
    set_cfg(l, s, h, 1'b0);
    len = exp_len(l, s, h, 1'b1);
    smp_q.push_back(len);
    pulse_start();
    // R12 request raised while active
    check("R12", "clk_req during sample", clk_req_o, 1);
    push_done(t_ref + len + CONV);
    drain();
    check("R12", "clk_req when idle", clk_req_o, aclk_en_i);
  endtask

  task automatic run_cont(input bit l, input logic [1:0] s, input bit h, input int n);
    int unsigned t;
    set_cfg(l, s, h, 1'b1);
    pulse_start();
    t = t_ref;
    for (int k = 0; k < n; k++) begin
      int unsigned len;
      len = exp_len(l, s, h, k == 0);  // R4 later conversions
      smp_q.push_back(len);
      t = t + len + CONV;
      push_done(t);
    end
    wait_cyc(t - 3);
    cont_i = 1'b0;
    drain();
    repeat (8) @(negedge clk);
    check("R6", "idle after run ends", sample_o, 0);
  endtask

  initial begin
    int unsigned seen0;
    logic [11:0] res0;
    logic        val0;
    rst_n = 1'b0;
    start_i = 1'b0; cont_i = 1'b0; lsmp_en_i = 1'b0; lsmp_sel_i = 2'd0; hs_en_i = 1'b0;
    lp_stop_i = 1'b0; nstop_i = 1'b0; aclk_en_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "result", result_o, 0);
    check("R1", "valid", valid_o, 0);
    check("R1", "sample", sample_o, 0);
    check("R1", "done", done_o, 0);
    check("R1", "clk_req", clk_req_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 short sampling, R3 long table
    run_single(1'b0, 2'd0, 1'b0);
    run_single(1'b0, 2'd0, 1'b1);
    for (int s = 0; s < 4; s++) run_single(1'b1, 2'(s), 1'b0);
    for (int s = 0; s < 4; s++) run_single(1'b1, 2'(s), 1'b1);

    // R4 R6 continuous runs
    run_cont(1'b0, 2'd0, 1'b0, 3);
    run_cont(1'b0, 2'd0, 1'b1, 2);
    run_cont(1'b1, 2'd2, 1'b0, 2);

    // R7 normal stop with async clock off aborts and keeps result
    set_cfg(1'b0, 2'd0, 1'b0, 1'b0);
    smp_q.push_back(6);
    pulse_start();
    wait_cyc(t_ref + 6 + 5);
    res0 = result_o; val0 = valid_o; seen0 = n_seen;
    nstop_i = 1'b1;
    @(negedge clk);
    check("R7", "sample after abort", sample_o, 0);
    check("R12", "clk_req after abort", clk_req_o, 0);
    check("R7", "result kept", result_o, res0);
    check("R7", "valid kept", valid_o, val0);
    // R11 trigger ignored while stop held
    pulse_start();
    check("R11", "sample while blocked", sample_o, 0);
    check("R11", "clk_req while blocked", clk_req_o, 0);
    nstop_i = 1'b0;
    repeat (30) @(negedge clk);
    check("R7", "no done after abort", n_seen, seen0);
    check("R7", "result still kept", result_o, res0);

    // R8 normal stop with async clock on does not abort
    aclk_en_i = 1'b1;
    smp_q.push_back(6);
    pulse_start();
    push_done(t_ref + 6 + CONV);
    wait_cyc(t_ref + 6 + 5);
    nstop_i = 1'b1;
    drain();
    nstop_i = 1'b0;
    check("R12", "clk_req idle with enable", clk_req_o, 1);
    check("R8", "valid after stop-tolerant run", valid_o, 1);

    // R9 low-power stop clears
    smp_q.push_back(6);
    pulse_start();
    wait_cyc(t_ref + 6 + 5);
    lp_stop_i = 1'b1;
    @(negedge clk);
    check("R9", "result cleared", result_o, 0);
    check("R9", "valid cleared", valid_o, 0);
    check("R12", "clk_req in low-power stop", clk_req_o, 1);
    lp_stop_i = 1'b0;
    aclk_en_i = 1'b0;
    n_cmp = 0;
    repeat (2) @(negedge clk);
    run_single(1'b0, 2'd0, 1'b0);
    check("R9", "count restarts at seed", result_o, SEED);

    // R9 reset mid-conversion clears
    run_single(1'b0, 2'd0, 1'b0);
    smp_q.push_back(6);
    pulse_start();
    wait_cyc(t_ref + 6 + 5);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", "reset clears result", result_o, 0);
    check("R9", "reset clears valid", valid_o, 0);
    rst_n = 1'b1;
    n_cmp = 0;
    repeat (4) @(negedge clk);
    run_single(1'b0, 2'd0, 1'b0);

    // R10 restart during convert, counted as first (R4)
    set_cfg(1'b0, 2'd0, 1'b0, 1'b0);
    smp_q.push_back(6);
    pulse_start();
    wait_cyc(t_ref + 6 + 4);
    smp_q.push_back(6);
    pulse_start();
    push_done(t_ref + 6 + CONV);
    drain();

    // R10 trigger collides with final convert cycle: restart wins
    smp_q.push_back(6);
    pulse_start();
    wait_cyc(t_ref + 6 + 15);
    smp_q.push_back(6);
    pulse_start();
    push_done(t_ref + 6 + CONV);
    drain();

    check("R5", "scoreboard empty", done_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule